// File: doc/BRIEF.md
# AC Test Receiver Capture Logic

This block is the digital back end of a test receiver that watches one leg of an AC-coupled or differential input during boundary-scan interconnect test. An analog front end, not part of this block, delivers two flags that say whether the pin currently sits above the upper hysteresis threshold or below the lower one. A plain level-detect input is also supplied. The block holds a one-bit hysteretic memory that is seeded from the boundary-scan cell on a preload strobe. While AC test operation is selected, only a threshold crossing that persists for a programmable number of clock cycles may overwrite that memory. A net that never toggles therefore hands back the seeded value, and a missing transition can be told apart from a real one.

When AC operation is not selected, the capture path reads the level-detect input directly and the threshold flags are ignored. A capture strobe registers the selected value into the output bit that feeds the capture stage of the boundary cell. A build parameter marks the receiver as the negative leg of a differential pair. In that case the memory stores the pin level, and the value seeded in or handed out is the complement of the boundary-cell value.

Top module: `trx_capture`

## Requirements
- R1: After reset the output bit is 0 and the hysteretic memory holds pin level 0. An AC capture straight after reset therefore returns 0 on the positive leg and 1 on the negative leg.
- R2: A cycle with preloadStrobe high loads the memory with preloadVal (complemented on the negative leg). The load takes priority over an edge that qualifies in the same cycle, and it discards any partly counted crossing. The load also works with AC operation off.
- R3: With acMode high, aboveHi high and belowLo low on T consecutive sampled cycles, where T is the qualification target, the memory becomes pin level 1 at the clock edge that samples the T-th cycle.
- R4: With acMode high, belowLo high and aboveHi low on T consecutive sampled cycles, the memory becomes pin level 0 at the clock edge that samples the T-th cycle.
- R5: A crossing that lasts fewer than T cycles leaves the memory unchanged. A cycle with neither flag, or with the opposite flag, ends the run, and the next run counts from 1.
- R6: A cycle with both flags high is invalid. It leaves the memory unchanged and ends the current run.
- R7: The qualification target T equals minCount, except that a minCount of 0 acts as 1.
- R8: With acMode high, a cycle with captureStrobe high registers the memory value it finds (before any update in that cycle) into capBit, complemented on the negative leg. capBit holds its value in all cycles without a capture strobe.
- R9: With acMode low, a capture registers levelIn into capBit (complemented on the negative leg). The threshold flags have no effect on the memory, so a value preloaded before AC operation is restored still reads back.
- R10: With NEG_LEG set to 1, the preload and the capture are both complemented while the edges keep their pin sense. A preload of v with no edge captures v. A qualified rising edge captures 0, and a qualified falling edge captures 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock used for qualification, preload and capture |
| rstN | input | 1 | Active-low synchronous reset |
| aboveHi | input | 1 | Comparator flag: pin is above the upper hysteresis threshold |
| belowLo | input | 1 | Comparator flag: pin is below the lower hysteresis threshold |
| levelIn | input | 1 | Level-detect result used when AC operation is off |
| acMode | input | 1 | 1 = AC edge tracking, 0 = plain level detection |
| minCount | input | CNT_W | Number of consecutive cycles that qualifies a crossing (0 acts as 1) |
| preloadStrobe | input | 1 | Seeds the memory from preloadVal |
| preloadVal | input | 1 | Value held in the boundary-scan cell |
| captureStrobe | input | 1 | Registers the test-data result into capBit |
| capBit | output | 1 | Test-data bit to the boundary-cell capture stage |

## Verification
The assertions check every cycle for the local rules:
- a preload lands exactly;
- a qualifying single-cycle crossing sets or clears the memory when the target is 1;
- invalid, idle and level-mode cycles leave the memory alone;
- a capture copies the right source with the leg inversion;
- capBit never moves without a strobe.

Only the bench scenarios can show the counting behaviour over whole runs:
- that exactly T cycles are needed for any target;
- that interrupted runs, opposite-direction runs and runs containing an invalid cycle restart the count;
- that a preload discards a partial run;
- that the negative leg returns complemented results over the same sweep.

// File: rtl/trx_capture_pkg.sv
`timescale 1ns/1ps
package trx_capture_pkg;
  // strobes from the qualification control to the memory datapath
  typedef struct packed {
    logic loadMem;
    logic setMem;
    logic clrMem;
    logic doCapture;
    logic selLevel;
  } ctl_t;
endpackage

// File: rtl/trx_capture_ctl.sv
`timescale 1ns/1ps
module trx_capture_ctl
  import trx_capture_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aboveHi,
  input  logic             belowLo,
  input  logic             acMode,
  input  logic [CNT_W-1:0] minCount,
  input  logic             preloadStrobe,
  input  logic             captureStrobe,
  output ctl_t             ctl
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] target;
  logic             runRise;
  logic             up;
  logic             dn;
  logic             sameRun;
  logic             fire;

  always_comb begin
    target  = (minCount == '0) ? ONE : minCount;
    up      = aboveHi & ~belowLo;
    dn      = belowLo & ~aboveHi;
    sameRun = (runCnt != '0) && (runRise == up);
    fire    = 1'b0;
    if (acMode && !preloadStrobe && (up || dn)) begin
      if (sameRun) fire = (runCnt < target) && ((runCnt + ONE) == target);
      else         fire = (target == ONE);
    end
    ctl.loadMem   = preloadStrobe;
    ctl.setMem    = fire & up;
    ctl.clrMem    = fire & dn;
    ctl.doCapture = captureStrobe;
    ctl.selLevel  = ~acMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      runRise <= 1'b0;
    end else if (preloadStrobe || !acMode || !(up || dn)) begin
      runCnt <= '0;
    end else if (sameRun) begin
      if (runCnt < target) runCnt <= runCnt + ONE;
    end else begin
      runCnt  <= ONE;
      runRise <= up;
    end
  end
endmodule

// File: rtl/trx_capture_dp.sv
`timescale 1ns/1ps
module trx_capture_dp
  import trx_capture_pkg::*;
#(
  parameter int NEG_LEG = 0
) (
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  logic preloadVal,
  input  logic levelIn,
  output logic memQ,
  output logic capBit
);
  logic legInv;

  generate
    if (NEG_LEG != 0) begin : g_minus
      assign legInv = 1'b1;
    end else begin : g_plus
      assign legInv = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memQ   <= 1'b0;
      capBit <= 1'b0;
    end else begin
      if (ctl.loadMem)      memQ <= preloadVal ^ legInv;
      else if (ctl.setMem)  memQ <= 1'b1;
      else if (ctl.clrMem)  memQ <= 1'b0;
      if (ctl.doCapture)
        capBit <= (ctl.selLevel ? levelIn : memQ) ^ legInv;
    end
  end
endmodule

// File: rtl/trx_capture.sv
`timescale 1ns/1ps
module trx_capture
  import trx_capture_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int NEG_LEG = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aboveHi,
  input  logic             belowLo,
  input  logic             levelIn,
  input  logic             acMode,
  input  logic [CNT_W-1:0] minCount,
  input  logic             preloadStrobe,
  input  logic             preloadVal,
  input  logic             captureStrobe,
  output logic             capBit
);
  ctl_t ctl;
  logic memQ;

  trx_capture_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .belowLo(belowLo),
    .acMode(acMode), .minCount(minCount), .preloadStrobe(preloadStrobe),
    .captureStrobe(captureStrobe), .ctl(ctl)
  );

  trx_capture_dp #(.NEG_LEG(NEG_LEG)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .preloadVal(preloadVal),
    .levelIn(levelIn), .memQ(memQ), .capBit(capBit)
  );
endmodule

// File: rtl/trx_capture_chk.sv
`timescale 1ns/1ps
module trx_capture_chk #(
  parameter int CNT_W   = 4,
  parameter int NEG_LEG = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             aboveHi,
  input logic             belowLo,
  input logic             levelIn,
  input logic             acMode,
  input logic [CNT_W-1:0] minCount,
  input logic             preloadStrobe,
  input logic             preloadVal,
  input logic             captureStrobe,
  input logic             capBit,
  input logic             memQ,
  input logic             setMem,
  input logic             clrMem
);
  localparam logic INV = (NEG_LEG != 0);

  p_preload_r2: assert property (@(posedge clk) disable iff (!rstN)
    preloadStrobe |=> memQ == ($past(preloadVal) ^ INV));

  p_rise_fast_r3: assert property (@(posedge clk) disable iff (!rstN)
    (acMode && aboveHi && !belowLo && minCount <= CNT_W'(1) && !preloadStrobe) |=> memQ);

  p_fall_fast_r4: assert property (@(posedge clk) disable iff (!rstN)
    (acMode && belowLo && !aboveHi && minCount <= CNT_W'(1) && !preloadStrobe) |=> !memQ);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (acMode && !aboveHi && !belowLo && !preloadStrobe) |=> $stable(memQ));

  p_both_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (acMode && aboveHi && belowLo && !preloadStrobe) |=> $stable(memQ));

  p_one_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setMem, clrMem}));

  p_cap_ac_r8: assert property (@(posedge clk) disable iff (!rstN)
    (captureStrobe && acMode) |=> capBit == ($past(memQ) ^ INV));

  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !captureStrobe |=> $stable(capBit));

  p_cap_dc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (captureStrobe && !acMode) |=> capBit == ($past(levelIn) ^ INV));

  p_dc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!acMode && !preloadStrobe) |=> $stable(memQ));
endmodule

bind trx_capture trx_capture_chk #(.CNT_W(CNT_W), .NEG_LEG(NEG_LEG)) u_chk (
  .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .belowLo(belowLo),
  .levelIn(levelIn), .acMode(acMode), .minCount(minCount),
  .preloadStrobe(preloadStrobe), .preloadVal(preloadVal),
  .captureStrobe(captureStrobe), .capBit(capBit), .memQ(memQ),
  .setMem(ctl.setMem), .clrMem(ctl.clrMem)
);

// File: tb/trx_capture_tb.sv
`timescale 1ns/1ps
module trx_capture_tb;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN;
  logic aboveHi, belowLo, levelIn, acMode;
  logic [CNT_W-1:0] minCount;
  logic preloadStrobe, preloadVal, captureStrobe;
  logic capBit, capBitNeg;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trx_capture #(.CNT_W(CNT_W), .NEG_LEG(0)) u_dut (
    .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .belowLo(belowLo),
    .levelIn(levelIn), .acMode(acMode), .minCount(minCount),
    .preloadStrobe(preloadStrobe), .preloadVal(preloadVal),
    .captureStrobe(captureStrobe), .capBit(capBit)
  );

  trx_capture #(.CNT_W(CNT_W), .NEG_LEG(1)) u_dutNeg (
    .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .belowLo(belowLo),
    .levelIn(levelIn), .acMode(acMode), .minCount(minCount),
    .preloadStrobe(preloadStrobe), .preloadVal(preloadVal),
    .captureStrobe(captureStrobe), .capBit(capBitNeg)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(logic act, logic exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic doPreload(logic v);
    preloadStrobe = 1'b1; preloadVal = v;
    tick();
    preloadStrobe = 1'b0;
  endtask

  task automatic drive(logic up, logic dn, int n);
    aboveHi = up; belowLo = dn;
    repeat (n) tick();
    aboveHi = 1'b0; belowLo = 1'b0;
  endtask

  task automatic capBoth(logic expPos, logic expNeg, string tag);
    captureStrobe = 1'b1;
    tick();
    captureStrobe = 1'b0;
    chk(capBit, expPos, {tag, " pos"});
    chk(capBitNeg, expNeg, {tag, " R10 neg"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; aboveHi = 0; belowLo = 0; levelIn = 0; acMode = 1'b1;
    minCount = '0; preloadStrobe = 0; preloadVal = 0; captureStrobe = 0;
    repeat (3) tick();
    chk(capBit, 1'b0, "R1 reset capBit pos");
    chk(capBitNeg, 1'b0, "R1 reset capBit neg");
    rstN = 1'b1;
    tick();
    capBoth(1'b0, 1'b1, "R1 memory after reset");

    // sweep over targets, directions, preloads and run lengths
    for (int mc = 0; mc <= 4; mc++) begin
      for (int d = 0; d < 2; d++) begin
        for (int p = 0; p < 2; p++) begin
          int tgt;
          tgt = (mc == 0) ? 1 : mc;
          for (int len = 0; len <= tgt + 1; len++) begin
            logic qual;
            string tag;
            minCount = CNT_W'(mc);
            doPreload(p[0]);
            drive(d[0], ~d[0], len);
            qual = (len >= tgt);
            tag = $sformatf("%s%s mc=%0d pre=%0d len=%0d",
                            (mc == 0) ? "R7 " : "",
                            !qual ? "R5 short" : (d != 0 ? "R3 rise" : "R4 fall"),
                            mc, p, len);
            capBoth(qual ? d[0] : p[0], qual ? ~d[0] : p[0], tag);
          end
        end
      end
    end

    // interrupted run restarts the count
    minCount = 4'd3;
    doPreload(1'b0);
    drive(1'b1, 1'b0, 2); drive(1'b0, 1'b0, 1); drive(1'b1, 1'b0, 2);
    capBoth(1'b0, 1'b0, "R5 gap restarts run");

    // opposite-direction run starts afresh and qualifies
    doPreload(1'b1);
    drive(1'b1, 1'b0, 2); drive(1'b0, 1'b1, 3);
    capBoth(1'b0, 1'b1, "R5 opposite run then R4 fall");

    // invalid cycle ends the run
    doPreload(1'b0);
    drive(1'b1, 1'b0, 2); drive(1'b1, 1'b1, 1); drive(1'b1, 1'b0, 2);
    capBoth(1'b0, 1'b0, "R6 both flags breaks run");

    minCount = 4'd1;
    doPreload(1'b1);
    drive(1'b1, 1'b1, 4);
    capBoth(1'b1, 1'b1, "R6 both flags hold memory");

    // preload overrides a same-cycle qualifying edge
    minCount = 4'd1;
    aboveHi = 1'b1;
    doPreload(1'b0);
    aboveHi = 1'b0;
    capBoth(1'b0, 1'b0, "R2 preload beats edge");

    // preload discards a partial run
    minCount = 4'd3;
    doPreload(1'b0);
    drive(1'b1, 1'b0, 2);
    aboveHi = 1'b1;
    doPreload(1'b0);
    drive(1'b1, 1'b0, 1);
    capBoth(1'b0, 1'b0, "R2 preload clears partial run");

    // capBit holds with no capture strobe
    minCount = 4'd1;
    doPreload(1'b1);
    capBoth(1'b1, 1'b1, "R8 capture preload");
    doPreload(1'b0);
    drive(1'b0, 1'b1, 3);
    tick();
    chk(capBit, 1'b1, "R8 hold pos");
    chk(capBitNeg, 1'b1, "R8 hold neg");

    // level mode
    acMode = 1'b0;
    levelIn = 1'b1;
    capBoth(1'b1, 1'b0, "R9 level high");
    levelIn = 1'b0;
    capBoth(1'b0, 1'b1, "R9 level low");
    doPreload(1'b1);
    drive(1'b0, 1'b1, 4);
    acMode = 1'b1;
    tick();
    capBoth(1'b1, 1'b1, "R9 flags ignored, R2 preload in level mode");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule